// File: doc/BRIEF.md
# Serial Register Access Master

This block is the host end of a three-wire serial link to a register-based device. A parallel command port takes an operation (write or read), a 7-bit register address and 30 bits of write data. From these the block builds 40-bit frames and drives the enable (active low), the serial clock and the serial data-out line. It samples the device's serial data return line to collect read results.

A write takes one frame. A read takes two frames. The first frame stores the wanted address in the device's pointer register, which is register 0. The second frame sends exactly the same pointer frame again while the device shifts the selected register back. Because the second frame repeats the first, nothing else in the device changes. When the read ends, the block presents the returned data, the echoed address and the chip id, and raises an error flag if the chip id is wrong.

The serial clock is the system clock divided by 2×(DIV+1). A one-cycle done pulse marks the end of every operation.

Top module: `serial_reg_master`

## Requirements
- R1: Each frame has exactly 40 rising edges of the serial clock. The enable goes low at least one system cycle before the first rising edge. It returns high only after the 40th rising edge.
- R2: Frame bits leave MSB first in this order: 30 data bits (frame bits 39..10), 7 register address bits (bits 9..3), then the chip address 3'b100 (bits 2..0).
- R3: SDI never changes in the cycle the serial clock rises or while it is high; it changes only together with a falling edge or at frame start. The serial clock is low whenever the enable is high.
- R4: Consecutive rising edges of the serial clock within a frame are exactly 2×(DIV+1) system cycles apart.
- R5: A write sends one frame carrying the command's data and register address.
- R6: The first frame of a read uses register address 0. Its data field holds the wanted address in bits 6..0, and all higher data bits are zero.
- R7: The second frame of a read is bit-identical to the first. After a read, the device's registers other than register 0 are unchanged, and register 0 holds the read address.
- R8: In the second frame, SDO is sampled on falling edges of the serial clock. The first 30 bits sampled form rd_data (first bit is the MSB), the next 7 form rd_addr and the last 3 form rd_cid.
- R9: Between the two frames of a read, the enable stays high for at least 2×(DIV+1) system cycles.
- R10: When an operation finishes, busy falls in the same cycle that done rises, and done lasts one cycle. A command presented while busy is ignored.
- R11: At the end of a read, cid_err is 1 exactly when the returned chip id is not 3'b100.
- R12: After reset the enable is high, the serial clock low, and busy and done are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd_valid | input | 1 | Command strobe, taken only when idle |
| cmd_read | input | 1 | 1 = read, 0 = write |
| cmd_addr | input | 7 | Register address |
| cmd_wdata | input | 30 | Write data |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle end-of-operation pulse |
| rd_data | output | 30 | Returned register data |
| rd_addr | output | 7 | Returned address field |
| rd_cid | output | 3 | Returned chip id field |
| cid_err | output | 1 | Returned chip id differs from 3'b100 |
| sen_n | output | 1 | Serial enable, active low |
| sck | output | 1 | Serial clock |
| sdi | output | 1 | Serial data to the device |
| sdo | input | 1 | Serial data from the device |

## Verification
The enable falls in the first cycle after a command is taken. The first rising edge of the serial clock comes DIV+1 cycles later, and each later rising edge follows 2×(DIV+1) cycles after the one before. The enable rises in the same cycle as the 40th falling edge. After one more serial clock period, either the next read frame starts or done pulses with busy low and the read results valid. Because each output's timing depends on the operation, the bench does not count cycles to find results. Cycle-exact timing is checked by monitors that timestamp serial clock edges and enable levels against a free-running cycle counter. Results are sampled at the falling system-clock edge on which done is first seen high, and again one cycle later to confirm the pulse has ended. A bus model of the device inside the bench logs every frame it receives, so field order and frame repetition are checked bit for bit.

// File: rtl/srm_pkg.sv
package srm_pkg;

    localparam int FRAME_W = 40;
    localparam int DATA_W  = 30;
    localparam int ADDR_W  = 7;
    localparam int CID_W   = 3;
    localparam int CNT_W   = $clog2(FRAME_W + 1);
    localparam logic [CID_W-1:0] CHIP_ID = 3'b100;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_RUN,
        ST_GAP
    } phase_e;

    typedef struct packed {
        phase_e              st;
        logic                sen_n;
        logic                sck;
        logic [CNT_W-1:0]    bits;
        logic                gap;
        logic                rd;
        logic                second;
        logic [ADDR_W-1:0]   addr;
        logic [DATA_W-1:0]   wdata;
        logic                busy;
        logic                done;
        logic [DATA_W-1:0]   rdata;
        logic [ADDR_W-1:0]   raddr;
        logic [CID_W-1:0]    rcid;
        logic                err;
    } ctl_t;

    // A read frame points register 0 at the wanted address.
    function automatic logic [FRAME_W-1:0] build_frame(
        input logic              rd,
        input logic [ADDR_W-1:0] a,
        input logic [DATA_W-1:0] d
    );
        if (rd)
            return {{(DATA_W-ADDR_W){1'b0}}, a, {ADDR_W{1'b0}}, CHIP_ID};
        else
            return {d, a, CHIP_ID};
    endfunction

endpackage

// File: rtl/srm_tick_gen.sv
module srm_tick_gen #(
    parameter int DIV_W = 8,
    parameter int DIV   = 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    output logic tick
);
    logic [DIV_W-1:0] cnt_q, cnt_d;

    assign tick = en && (cnt_q == DIV_W'(DIV));

    always_comb begin
        if (!en || tick) cnt_d = '0;
        else             cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    // R4
    div_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= DIV_W'(DIV));
endmodule

// File: rtl/srm_shifter.sv
module srm_shifter #(
    parameter int W = 40
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         shift,
    input  logic         sin,
    output logic         sout,
    output logic [W-1:0] word
);
    logic [W-1:0] tx_q, tx_d, rx_q, rx_d;

    assign sout = tx_q[W-1];
    assign word = rx_q;

    always_comb begin
        tx_d = tx_q;
        rx_d = rx_q;
        if (load) begin
            tx_d = load_val;
        end else if (shift) begin
            tx_d = {tx_q[W-2:0], 1'b0};
            rx_d = {rx_q[W-2:0], sin};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tx_q <= '0;
            rx_q <= '0;
        end else begin
            tx_q <= tx_d;
            rx_q <= rx_d;
        end
    end

    // R2
    load_shift_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(load && shift));
endmodule

// File: rtl/serial_reg_master.sv
module serial_reg_master
    import srm_pkg::*;
#(
    parameter int DIV_W = 8,
    parameter int DIV   = 1
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cmd_valid,
    input  logic        cmd_read,
    input  logic [6:0]  cmd_addr,
    input  logic [29:0] cmd_wdata,
    output logic        busy,
    output logic        done,
    output logic [29:0] rd_data,
    output logic [6:0]  rd_addr,
    output logic [2:0]  rd_cid,
    output logic        cid_err,
    output logic        sen_n,
    output logic        sck,
    output logic        sdi,
    input  logic        sdo
);
    ctl_t               q, d;
    logic               tick, load, shift;
    logic [FRAME_W-1:0] frame_val, rx_word;

    srm_tick_gen #(.DIV_W(DIV_W), .DIV(DIV)) u_tick (
        .clk(clk), .rst_n(rst_n), .en(q.st != ST_IDLE), .tick(tick)
    );

    srm_shifter #(.W(FRAME_W)) u_shift (
        .clk(clk), .rst_n(rst_n), .load(load), .load_val(frame_val),
        .shift(shift), .sin(sdo), .sout(sdi), .word(rx_word)
    );

    always_comb begin
        d         = q;
        d.done    = 1'b0;
        load      = 1'b0;
        shift     = 1'b0;
        frame_val = build_frame(q.rd, q.addr, q.wdata);
        case (q.st)
            ST_IDLE: begin
                if (cmd_valid) begin
                    d.rd      = cmd_read;
                    d.addr    = cmd_addr;
                    d.wdata   = cmd_wdata;
                    d.busy    = 1'b1;
                    d.second  = 1'b0;
                    d.st      = ST_RUN;
                    d.sen_n   = 1'b0;
                    d.sck     = 1'b0;
                    d.bits    = '0;
                    load      = 1'b1;
                    frame_val = build_frame(cmd_read, cmd_addr, cmd_wdata);
                end
            end
            ST_RUN: begin
                if (tick) begin
                    if (!q.sck) begin
                        d.sck = 1'b1;
                    end else begin
                        d.sck  = 1'b0;
                        shift  = 1'b1;
                        d.bits = q.bits + 1'b1;
                        if (q.bits == CNT_W'(FRAME_W - 1)) begin
                            d.st    = ST_GAP;
                            d.sen_n = 1'b1;
                            d.gap   = 1'b0;
                        end
                    end
                end
            end
            ST_GAP: begin
                if (tick) begin
                    if (!q.gap) begin
                        d.gap = 1'b1;
                    end else if (q.rd && !q.second) begin
                        d.second = 1'b1;
                        d.st     = ST_RUN;
                        d.sen_n  = 1'b0;
                        d.bits   = '0;
                        load     = 1'b1;
                    end else begin
                        d.st   = ST_IDLE;
                        d.busy = 1'b0;
                        d.done = 1'b1;
                        if (q.rd) begin
                            d.rdata = rx_word[FRAME_W-1 -: DATA_W];
                            d.raddr = rx_word[CID_W +: ADDR_W];
                            d.rcid  = rx_word[CID_W-1:0];
                            d.err   = (rx_word[CID_W-1:0] != CHIP_ID);
                        end
                    end
                end
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q       <= '0;
            q.sen_n <= 1'b1;
        end else begin
            q <= d;
        end
    end

    assign busy    = q.busy;
    assign done    = q.done;
    assign rd_data = q.rdata;
    assign rd_addr = q.raddr;
    assign rd_cid  = q.rcid;
    assign cid_err = q.err;
    assign sen_n   = q.sen_n;
    assign sck     = q.sck;

    // R3
    idle_sck_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sen_n |-> !sck);
    // R3
    sdi_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sck) |-> $stable(sdi));
    // R1
    frame_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sen_n) |-> (q.bits == CNT_W'(FRAME_W)));
    // R10
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    // R10
    busy_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done);
    // R10
    cmd_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && cmd_valid) |=> ($stable(q.addr) && $stable(q.rd)));
endmodule

// File: tb/tb_serial_reg_master.sv
module tb_serial_reg_master;
    localparam int TDIV    = 2;
    localparam int SCK_CYC = 2 * (TDIV + 1);

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0, cmd_read = 1'b0;
    logic [6:0]  cmd_addr = '0;
    logic [29:0] cmd_wdata = '0;
    logic        busy, done, cid_err, sen_n, sck, sdi;
    logic        sdo = 1'b0;
    logic [29:0] rd_data;
    logic [6:0]  rd_addr;
    logic [2:0]  rd_cid;

    int tests = 0, fails = 0;

    always #2.5 clk = ~clk;

    serial_reg_master #(.DIV_W(8), .DIV(TDIV)) dut (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_read(cmd_read),
        .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata), .busy(busy), .done(done),
        .rd_data(rd_data), .rd_addr(rd_addr), .rd_cid(rd_cid), .cid_err(cid_err),
        .sen_n(sen_n), .sck(sck), .sdi(sdi), .sdo(sdo)
    );

    // ---------------- device model ----------------
    logic [29:0] regs    [128];
    logic [29:0] exp_mem [128];
    logic [39:0] flog    [32];
    int          frise   [32];
    int          nfr = 0, nrise = 0;
    logic [39:0] rx_sh = '0, obuf = '0;
    logic        bad_cid = 1'b0;

    int cyc = 0, last_rise = 0, fall_cyc = 0;
    int per_err = 0, lead_err = 0, sdi_err = 0, gap_run = 0, last_gap = 0, n_done = 0;
    logic prev_sdi = 1'b0;

    initial begin
        for (int i = 0; i < 128; i++) begin
            regs[i]    = 30'((i * 32'h0123_4567) ^ 32'h2AAA_5555);
            exp_mem[i] = regs[i];
        end
        regs[0]    = '0;
        exp_mem[0] = '0;
    end

    always @(posedge clk) begin
        cyc++;
        if (done) n_done++;
    end

    always @(negedge sen_n) begin
        nrise    = 0;
        fall_cyc = cyc;
        obuf     = {regs[regs[0][6:0]], regs[0][6:0], bad_cid ? 3'b011 : 3'b100};
    end

    always @(posedge sck) begin
        if (nrise == 0 && cyc - fall_cyc < 1) lead_err++;
        if (nrise > 0 && cyc - last_rise != SCK_CYC) per_err++;
        last_rise = cyc;
        rx_sh = {rx_sh[38:0], sdi};
        sdo   = obuf[39];
        obuf  = {obuf[38:0], 1'b0};
        nrise++;
    end

    always @(posedge sen_n) begin
        if (nrise > 0) begin
            if (nfr < 32) begin
                flog[nfr]  = rx_sh;
                frise[nfr] = nrise;
            end
            nfr++;
            if (nrise == 40) regs[rx_sh[9:3]] = rx_sh[39:10];
            nrise = 0;
        end
    end

    always @(negedge clk) begin
        if (!sen_n && sck && sdi !== prev_sdi) sdi_err++;
        if (sen_n && sck) sdi_err++;
        prev_sdi = sdi;
        if (sen_n && busy) gap_run++;
        else if (!sen_n && gap_run > 0) begin
            last_gap = gap_run;
            gap_run  = 0;
        end else if (!busy) gap_run = 0;
    end

    // ---------------- helpers ----------------
    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic issue(input logic rd, input logic [6:0] a, input logic [29:0] dat);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_read = rd; cmd_addr = a; cmd_wdata = dat;
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    task automatic wait_done(output bit ok);
        ok = 1'b0;
        for (int i = 0; i < 3000; i++) begin
            if (done) begin ok = 1'b1; break; end
            @(negedge clk);
        end
        chk(ok, "R10 done seen", 64'(ok), 64'd1);
    endtask

    task automatic t_reset();
        chk(sen_n === 1'b1 && sck === 1'b0, "R12 serial idle", {sen_n, sck}, 2'b10);
        chk(busy === 1'b0 && done === 1'b0, "R12 busy/done", {busy, done}, 2'b00);
    endtask

    task automatic t_write(input logic [6:0] a, input logic [29:0] dat);
        int f0 = nfr;
        bit ok;
        issue(1'b0, a, dat);
        exp_mem[a] = dat;
        wait_done(ok);
        chk(busy === 1'b0, "R10 busy low with done", busy, 0);
        @(negedge clk);
        chk(done === 1'b0, "R10 done one cycle", done, 0);
        chk(nfr == f0 + 1, "R5 one frame", nfr - f0, 1);
        chk(frise[f0] == 40, "R1 40 rises", frise[f0], 40);
        chk(flog[f0] == {dat, a, 3'b100}, "R2 R5 frame bits", flog[f0], {dat, a, 3'b100});
        chk(regs[a] == dat, "R5 device reg", regs[a], dat);
    endtask

    task automatic t_read(input logic [6:0] a, input bit bad);
        int f0 = nfr;
        bit ok;
        logic [39:0] ef = {23'b0, a, 7'b0, 3'b100};
        bad_cid = bad;
        issue(1'b1, a, 30'h3FFF_FFFF);
        wait_done(ok);
        chk(nfr == f0 + 2, "R6 two frames", nfr - f0, 2);
        chk(flog[f0] == ef, "R6 pointer frame", flog[f0], ef);
        chk(flog[f0 + 1] == flog[f0], "R7 repeat frame", flog[f0 + 1], flog[f0]);
        chk(frise[f0 + 1] == 40, "R1 40 rises frame2", frise[f0 + 1], 40);
        chk(last_gap >= SCK_CYC, "R9 gap", last_gap, SCK_CYC);
        chk(rd_data == exp_mem[a], "R8 rd_data", rd_data, exp_mem[a]);
        chk(rd_addr == a, "R8 rd_addr", rd_addr, a);
        chk(rd_cid == (bad ? 3'b011 : 3'b100), "R8 rd_cid", rd_cid, bad ? 3'b011 : 3'b100);
        chk(cid_err == bad, "R11 cid_err", cid_err, bad);
        chk(regs[a] == exp_mem[a] && regs[0] == 30'(a), "R7 device unchanged",
            {regs[0][6:0], regs[a]}, {a, exp_mem[a]});
        @(negedge clk);
        chk(done === 1'b0 && busy === 1'b0, "R10 done one cycle", {done, busy}, 0);
        bad_cid = 1'b0;
    endtask

    task automatic t_busy_ignore();
        int f0 = nfr, d0 = n_done;
        bit ok;
        issue(1'b0, 7'd9, 30'h0ABC_DEF1);
        exp_mem[9] = 30'h0ABC_DEF1;
        repeat (3) @(negedge clk);
        cmd_valid = 1'b1; cmd_read = 1'b1; cmd_addr = 7'd5;
        @(negedge clk);
        cmd_valid = 1'b0;
        wait_done(ok);
        repeat (200) @(negedge clk);
        chk(nfr == f0 + 1, "R10 busy cmd ignored frames", nfr - f0, 1);
        chk(n_done == d0 + 1, "R10 busy cmd ignored done", n_done - d0, 1);
        chk(regs[9] == 30'h0ABC_DEF1, "R10 write intact", regs[9], 30'h0ABC_DEF1);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        t_reset();
        t_write(7'd3, 30'h2A5A_5A5A);
        t_write(7'd127, 30'h3FFF_FFFF);
        t_write(7'd64, 30'h0000_0001);
        t_read(7'd3, 1'b0);
        t_read(7'd127, 1'b0);
        t_read(7'd42, 1'b0);
        t_read(7'd64, 1'b1);
        t_busy_ignore();
        chk(per_err == 0, "R4 sck period", per_err, 0);
        chk(lead_err == 0, "R1 enable lead", lead_err, 0);
        chk(sdi_err == 0, "R3 sdi hold / sck idle", sdi_err, 0);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        tests++;
        fails++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule